// File: doc/BRIEF.md
# Command FIFO with Status Word

This block sits between a host register port and the drawing pipeline. Host writes to the command space carry a register index and a data word. They are queued in a first-in first-out buffer and presented to the downstream engines through a valid/ready pair. Writes and reads aimed at the status space bypass the queue.

The 32-bit status word combines several fields:
- a live count of free queue slots;
- a framebuffer-stage busy bit;
- a raster-stage busy bit, which is also raised while any command is still queued;
- two sticky error flags, one for a write that found the queue full and one for an illegal read of the write-only command space.

Software clears either flag by writing a one to its bit. The engines are idle only when both busy bits read zero.

Top module: `cmd_fifo_stat`

## Requirements
- R1: While `rst_ni` is low and after its release, the queue is empty. `cmd_valid_o` is 0, both error flags are 0, and the free field reads DEPTH.
- R2: Status bits [11:0] hold DEPTH minus the number of queued entries. The field changes at the clock edge that performs an enqueue or a dequeue. DEPTH is a parameter of at most 4095.
- R3: Queued commands leave in arrival order. The index arrives on `cmd_idx_o` and the data on `cmd_data_o`. `cmd_valid_o` is 1 whenever the queue is non-empty. An entry is removed at a clock edge where `cmd_valid_o` and `cmd_ready_i` are both 1. Otherwise the head stays stable.
- R4: A command write (`host_wr_i`=1, `host_stat_sel_i`=0) that sees a free count of 0 is discarded, and it sets the overflow flag in status bit 31. The queued contents stay as they were.
- R5: A read of the command space (`host_rd_i`=1, `host_stat_sel_i`=0) returns 0 on `host_rdata_o` and sets the read-error flag in status bit 30.
- R6: Both error flags are sticky. A status write (`host_wr_i`=1, `host_stat_sel_i`=1) with data bit 31 or bit 30 at 1 clears the matching flag only. Data bits at 0 leave the flags untouched.
- R7: Status bit 24 follows `fb_busy_i`. Status bit 25 is `rp_busy_i` OR (queue non-empty). Every bit not named in R2 and R4 to R7 reads 0.
- R8: During a status read (`host_rd_i`=1, `host_stat_sel_i`=1), `host_rdata_o` shows the current status word in the same cycle, combinationally. With no read strobe it is 0.
- R9: An accepted enqueue and a dequeue at the same edge leave the free count unchanged, and the new entry lines up behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_stat_sel_i | input | 1 | 1 selects the status space, 0 the command space |
| host_idx_i | input | IDX_W | Register index carried with a command write |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data |
| cmd_valid_o | output | 1 | Head command available |
| cmd_ready_i | input | 1 | Downstream takes the head command |
| cmd_idx_o | output | IDX_W | Head command index |
| cmd_data_o | output | 32 | Head command data |
| fb_busy_i | input | 1 | Framebuffer stage busy |
| rp_busy_i | input | 1 | Raster stage busy |

## Verification
An occupancy counter that drifts shows up at once in the free field of the next status read. Once the queue reaches its true limit, it also shows up as a missing or spurious overflow flag. A corrupted read or write pointer shows up as a wrong index or data word on the command output at the first pop that follows. Errors in the flag logic show up either as a flag that survives a write-one-to-clear or as a flag lost without a clear, on the very next status read.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int unsigned HOST_W      = 32;
  localparam int unsigned FREE_W      = 12;
  localparam int unsigned FB_BUSY_BIT = 24;
  localparam int unsigned RP_BUSY_BIT = 25;
  localparam int unsigned RDERR_BIT   = 30;
  localparam int unsigned OVF_BIT     = 31;
  localparam int unsigned MAX_DEPTH   = 4095;
  localparam int unsigned N_FLAGS     = 2;
  // flag slot order inside the sticky flag vector
  localparam int unsigned FLG_RDERR   = 0;
  localparam int unsigned FLG_OVF     = 1;
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 40,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] used_o
);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] used_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      used_q   <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
    end
  end

  assign dout_o  = mem_q[rd_ptr_q];
  assign empty_o = (used_q == '0);
  assign full_o  = (used_q == FULLC);
  assign used_o  = used_q;
endmodule

// File: rtl/cmdq_flags.sv
module cmdq_flags
  import cmdq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_FLAGS-1:0] set_i,
  input  logic [N_FLAGS-1:0] clr_i,
  output logic [N_FLAGS-1:0] flag_o
);
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    logic q;
    // set wins over clear so a fresh event is never lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/cmdq_status.sv
module cmdq_status
  import cmdq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0]   used_i,
  input  logic               nonempty_i,
  input  logic               fb_busy_i,
  input  logic               rp_busy_i,
  input  logic [N_FLAGS-1:0] flag_i,
  output logic [HOST_W-1:0]  stat_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  logic [CNT_W-1:0] free;

  assign free = DEPTH_C - used_i;

  always_comb begin
    stat_o              = '0;
    stat_o[FREE_W-1:0]  = FREE_W'(free);
    stat_o[FB_BUSY_BIT] = fb_busy_i;
    stat_o[RP_BUSY_BIT] = rp_busy_i | nonempty_i;
    stat_o[RDERR_BIT]   = flag_i[FLG_RDERR];
    stat_o[OVF_BIT]     = flag_i[FLG_OVF];
  end
endmodule

// File: rtl/cmd_fifo_stat.sv
module cmd_fifo_stat
  import cmdq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic              host_stat_sel_i,
  input  logic [IDX_W-1:0]  host_idx_i,
  input  logic [HOST_W-1:0] host_wdata_i,
  output logic [HOST_W-1:0] host_rdata_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [IDX_W-1:0]  cmd_idx_o,
  output logic [HOST_W-1:0] cmd_data_o,
  input  logic              fb_busy_i,
  input  logic              rp_busy_i
);
  localparam int unsigned ENT_W = IDX_W + HOST_W;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic               wr_cmd, rd_cmd, wr_stat, rd_stat;
  logic               push, pop, empty, full;
  logic [CNT_W-1:0]   used;
  logic [ENT_W-1:0]   head;
  logic [N_FLAGS-1:0] flg_set, flg_clr, flags;
  logic [HOST_W-1:0]  stat_word;

  assign wr_cmd  = host_wr_i & ~host_stat_sel_i;
  assign rd_cmd  = host_rd_i & ~host_stat_sel_i;
  assign wr_stat = host_wr_i &  host_stat_sel_i;
  assign rd_stat = host_rd_i &  host_stat_sel_i;

  // a full queue drops the write even if a pop happens in the same cycle
  assign push = wr_cmd & ~full;
  assign pop  = cmd_ready_i & ~empty;

  cmdq_store #(.DEPTH(DEPTH), .W(ENT_W)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .din_i  ({host_idx_i, host_wdata_i}),
    .dout_o (head),
    .empty_o(empty),
    .full_o (full),
    .used_o (used)
  );

  always_comb begin
    flg_set            = '0;
    flg_clr            = '0;
    flg_set[FLG_OVF]   = wr_cmd & full;
    flg_set[FLG_RDERR] = rd_cmd;
    flg_clr[FLG_OVF]   = wr_stat & host_wdata_i[OVF_BIT];
    flg_clr[FLG_RDERR] = wr_stat & host_wdata_i[RDERR_BIT];
  end

  cmdq_flags i_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (flg_set),
    .clr_i (flg_clr),
    .flag_o(flags)
  );

  cmdq_status #(.DEPTH(DEPTH)) i_status (
    .used_i    (used),
    .nonempty_i(~empty),
    .fb_busy_i (fb_busy_i),
    .rp_busy_i (rp_busy_i),
    .flag_i    (flags),
    .stat_o    (stat_word)
  );

  assign host_rdata_o = rd_stat ? stat_word : '0;
  assign cmd_valid_o  = ~empty;
  assign {cmd_idx_o, cmd_data_o} = head;
endmodule

// File: rtl/cmd_fifo_stat_chk.sv
module cmd_fifo_stat_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_wr_i,
  input logic             host_rd_i,
  input logic             host_stat_sel_i,
  input logic [31:0]      host_wdata_i,
  input logic             cmd_valid_o,
  input logic             cmd_ready_i,
  input logic [IDX_W-1:0] cmd_idx_o,
  input logic [31:0]      cmd_data_o,
  input logic [31:0]      stat_word
);
  // R2
  free_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_word[11:0] <= 12'(DEPTH));

  // R3
  valid_vs_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o == (stat_word[11:0] != 12'(DEPTH)));

  // R3
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> $stable(cmd_data_o) && $stable(cmd_idx_o));

  // R4
  overflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && !host_stat_sel_i && stat_word[11:0] == 12'd0 |=> stat_word[31]);

  // R5
  rd_err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && !host_stat_sel_i |=> stat_word[30]);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_word[31] && !(host_wr_i && host_stat_sel_i && host_wdata_i[31]) |=> stat_word[31]);

  // R9
  push_pop_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && !host_stat_sel_i && stat_word[11:0] != 12'd0 && cmd_valid_o && cmd_ready_i
    |=> $stable(stat_word[11:0]));
endmodule

bind cmd_fifo_stat cmd_fifo_stat_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .host_wr_i      (host_wr_i),
  .host_rd_i      (host_rd_i),
  .host_stat_sel_i(host_stat_sel_i),
  .host_wdata_i   (host_wdata_i),
  .cmd_valid_o    (cmd_valid_o),
  .cmd_ready_i    (cmd_ready_i),
  .cmd_idx_o      (cmd_idx_o),
  .cmd_data_o     (cmd_data_o),
  .stat_word      (stat_word)
);

// File: tb/test_cmd_fifo_stat.sv
module test_cmd_fifo_stat;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned IDX_W = 8;
  // [39:38] op (0 idle,1 cmd write,2 status read,3 cmd read), [37] fb, [36] rp, [31:0] data/expected
  localparam int NV = 11;
  localparam logic [39:0] VEC [NV] = '{
    40'h80_00000004, 40'h40_A0000001, 40'hA0_03000003, 40'h40_B0000002,
    40'h40_C0000003, 40'h40_D0000004, 40'h90_02000000, 40'h40_EEEEEEEE,
    40'h80_82000000, 40'hC0_00000000, 40'h80_C2000000
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic host_wr_i = 0, host_rd_i = 0, host_stat_sel_i = 0, cmd_ready_i = 0;
  logic fb_busy_i = 0, rp_busy_i = 0;
  logic [IDX_W-1:0] host_idx_i = '0;
  logic [31:0] host_wdata_i = '0;
  logic [31:0] host_rdata_o, cmd_data_o;
  logic [IDX_W-1:0] cmd_idx_o;
  logic cmd_valid_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  cmd_fifo_stat #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_cmd_fifo_stat (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, leave 1 ns for combinational settling before sampling
  task automatic drive(input bit wr, input bit rd, input bit sel, input bit rdy,
                       input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk_i);
    host_wr_i = wr; host_rd_i = rd; host_stat_sel_i = sel; cmd_ready_i = rdy;
    host_idx_i = idx; host_wdata_i = d;
    #1;
  endtask

  task automatic idle(input bit rdy);
    drive(0, 0, 0, rdy, 8'h0, 32'h0);
  endtask

  task automatic stat_rd(input string req, input logic [31:0] exp);
    drive(0, 1, 1, 0, 8'h0, 32'h0);
    chk(req, host_rdata_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] exp_d [4] = '{32'hA0000001, 32'hB0000002, 32'hC0000003, 32'hD0000004};
    #5;
    // R1 reset state
    chk("R1 valid in reset", {31'b0, cmd_valid_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      op = VEC[v][39:38];
      fb_busy_i = VEC[v][37];
      rp_busy_i = VEC[v][36];
      case (op)
        2'd1: begin
          drive(1, 0, 0, 0, VEC[v][7:0] ^ 8'h5A, VEC[v][31:0]);
          chk("R8 no read data on write", host_rdata_o, 32'h0);
        end
        2'd2: begin
          drive(0, 1, 1, 0, 8'h0, 32'h0);
          chk("R2 R4 R7 status table", host_rdata_o, VEC[v][31:0]);
        end
        default: begin
          drive(0, 1, 0, 0, 8'h0, 32'h0);
          chk("R5 command read data", host_rdata_o, VEC[v][31:0]);
        end
      endcase
    end
    fb_busy_i = 0; rp_busy_i = 0;

    // R3 order and R4 dropped entry absent
    for (int k = 0; k < 4; k++) begin
      idle(1);
      chk("R3 head data", cmd_data_o, exp_d[k]);
      chk("R3 head idx", {24'h0, cmd_idx_o}, {24'h0, exp_d[k][7:0] ^ 8'h5A});
    end
    idle(0);
    chk("R3 empty after drain", {31'b0, cmd_valid_o}, 32'h0);
    stat_rd("R6 flags sticky", 32'hC0000004);

    // R6 write-one-to-clear
    drive(1, 0, 1, 0, 8'h0, 32'h80000000);
    stat_rd("R6 clear overflow only", 32'h40000004);
    drive(1, 0, 1, 0, 8'h0, 32'h00000000);
    stat_rd("R6 zero write no effect", 32'h40000004);
    drive(1, 0, 1, 0, 8'h0, 32'h40000000);
    stat_rd("R6 clear read error", 32'h00000004);

    // R9 simultaneous push and pop
    drive(1, 0, 0, 0, 8'h11, 32'h11111111);
    drive(1, 0, 0, 1, 8'h22, 32'h22222222);
    chk("R9 head before pop", cmd_data_o, 32'h11111111);
    stat_rd("R9 free kept", 32'h02000003);
    chk("R9 new head", cmd_data_o, 32'h22222222);
    idle(1);
    idle(0);

    // R7 busy aggregation
    fb_busy_i = 1;
    stat_rd("R7 fb busy", 32'h01000004);
    fb_busy_i = 0; rp_busy_i = 1;
    stat_rd("R7 rp busy", 32'h02000004);
    rp_busy_i = 0;
    stat_rd("R7 idle", 32'h00000004);

    // R1 reset mid-run
    drive(1, 0, 0, 0, 8'h33, 32'h33333333);
    drive(0, 1, 0, 0, 8'h0, 32'h0);
    drive(0, 1, 1, 0, 8'h0, 32'h0);
    chk("R1 pre-reset status", host_rdata_o, 32'h42000003);
    rst_ni = 1'b0;
    #0.5;
    chk("R1 status in reset", host_rdata_o, 32'h00000004);
    chk("R1 valid in reset", {31'b0, cmd_valid_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    stat_rd("R1 status after reset", 32'h00000004);
    idle(0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule